// File: doc/BRIEF.md
# SD SPI Block Data Mover

This unit carries the data phase of an SD card transfer in SPI mode, once a command engine has had a read or write command accepted by the card. It talks to the card one byte at a time through a byte-exchange port on an SPI shifter. On the other side it has a byte output stream for read data and a byte input stream for write data, and both streams can be stalled.

For a read, the unit polls the card with 0xFF fill bytes until the 0xFE start token appears, or gives up after a fixed number of polls. It then hands out one block of data bytes and drops the two CRC bytes that follow. For a write, it sends the start token, the block of data, two dummy CRC bytes, and a poll that reads the data response token. It then polls until the card stops signalling busy.

A block count above one selects multi-block framing. In a multi-block read, the data phase of every block repeats; the command engine sends the stop command afterwards. In a multi-block write, every block uses the multi-block token and the transfer ends with a stop token. The card address is derived from the byte address at start. High-capacity cards take a block index, so the byte address is shifted down. A one-cycle done pulse reports a status code.

Top module: `sdx_block_xfer`

## Requirements
- R1: While reset is asserted, and until a start is seen after reset, `busy`, `done`, `spi_req`, `rd_valid` and `wr_ready` are all low.
- R2: A start seen while idle captures the operation. From the next cycle until done, `card_addr` holds `byte_addr >> 9` when `high_cap` is 1 and `byte_addr` when it is 0, with BLK_BYTES = 512. `multi` is 1 exactly when `blk_count` > 1. A count of 0 is handled as a single block.
- R3: A read polls with 0xFF. Every received byte other than 0xFE counts as one poll. A 0xFE received on poll number TOKEN_TRIES or earlier starts the data. If TOKEN_TRIES polls bring no 0xFE, the unit ends with status 1 (timeout), makes no further exchange and outputs no data.
- R4: After the token, exactly BLK_BYTES received bytes appear on `rd_data`, in order. Two more exchanges are then made and their bytes discarded. In a multi-block read, this token/data/CRC sequence repeats for each of `blk_count` blocks, with a fresh poll budget per block.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` stays unchanged.
- R6: Each written block is sent as a token, then BLK_BYTES bytes taken in order from the write stream, then 0xFF, 0xFF, then one 0xFF whose received byte is the data response. The token is 0xFE in single mode and 0xFC for every block in multi mode.
- R7: The data response is decoded from its low five bits: 0x05 gives status 0 (ok), 0x0B gives 2 (CRC error), 0x0D gives 3 (write error), and any other value gives 4 (rejected).
- R8: After every data response, including a failing one, the unit sends 0xFF until it receives 0xFF.
- R9: In multi mode, the write sequence ends after the last block or after the first block whose status is not ok. The unit then sends 0xFD, discards the next exchanged byte, and polls with 0xFF until 0xFF is received. The remaining write data is never fetched. Single mode sends no stop token.
- R10: `done` is a one-cycle pulse with `status` valid, and `busy` is low in the following cycle. A start seen while busy is ignored.
- R11: `spi_req` stays high with `spi_tx` unchanged until the cycle in which `spi_ack` is high. That cycle completes one byte exchange, with `spi_rx` holding the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| is_write | input | 1 | 1 = write, 0 = read |
| high_cap | input | 1 | Card takes block-unit addresses |
| blk_count | input | CNT_W | Number of blocks (0 treated as 1) |
| byte_addr | input | ADDR_W | Byte address of the first block |
| busy | output | 1 | Operation in progress |
| multi | output | 1 | Multi-block framing selected |
| card_addr | output | ADDR_W | Address the command engine sends |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 timeout, 2 CRC, 3 write error, 4 rejected |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Exchange complete |
| spi_rx | input | 8 | Byte received |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Unit takes write byte |

## Verification
An acknowledged exchange is consumed at the rising edge on which `spi_ack` is high. The next request and byte are presented from that same edge. A read byte becomes visible on `rd_data` one cycle after its exchange completes. `done` rises one cycle after the final exchange, and `card_addr`, `multi` and `busy` are valid one cycle after the start. The bench drives every input at the falling edge and samples at the falling edge, so each value is read half a cycle after the edge that produced it. The bench's card model compares each outgoing byte against the expected queue at the moment it acknowledges that byte. The checks made at done confirm that no scripted exchange was left unused and none was added.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RTOK, S_RDAT, S_RPUSH, S_RCRC,
    S_WTOK, S_WFETCH, S_WDAT, S_WCRC, S_WRESP,
    S_WBUSY, S_WSTOP, S_SBUSY, S_DONE
  } sdx_state_e;

  typedef enum logic [2:0] {
    XS_OK      = 3'd0,
    XS_TIMEOUT = 3'd1,
    XS_CRC     = 3'd2,
    XS_WRITE   = 3'd3,
    XS_REJECT  = 3'd4
  } sdx_status_e;

  localparam logic [7:0] TK_SINGLE = 8'hFE;
  localparam logic [7:0] TK_MULTI  = 8'hFC;
  localparam logic [7:0] TK_STOP   = 8'hFD;
  localparam logic [7:0] FILL      = 8'hFF;

endpackage

// File: rtl/sdx_rst_sync.sv
module sdx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdx_addr_map.sv
module sdx_addr_map #(
  parameter int ADDR_W   = 32,
  parameter int BLK_LOG2 = 9
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              high_cap,
  output logic [ADDR_W-1:0] card_addr
);
  // R2: block-unit addressing for high-capacity cards
  always_comb begin
    if (high_cap) card_addr = byte_addr >> BLK_LOG2;
    else          card_addr = byte_addr;
  end
endmodule

// File: rtl/sdx_resp_decode.sv
module sdx_resp_decode
  import sdx_pkg::*;
(
  input  logic [4:0]  tok,
  output sdx_status_e code
);
  // R7: data response decode on the low five bits
  always_comb begin
    unique case (tok)
      5'h05:   code = XS_OK;
      5'h0B:   code = XS_CRC;
      5'h0D:   code = XS_WRITE;
      default: code = XS_REJECT;
    endcase
  end
endmodule

// File: rtl/sdx_block_xfer.sv
module sdx_block_xfer
  import sdx_pkg::*;
#(
  parameter int BLK_BYTES   = 512,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int TOKEN_TRIES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic              high_cap,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic              busy,
  output logic              multi,
  output logic [ADDR_W-1:0] card_addr,
  output logic              done,
  output logic [2:0]        status,
  output logic              spi_req,
  output logic [7:0]        spi_tx,
  input  logic              spi_ack,
  input  logic [7:0]        spi_rx,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready
);
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam int TRY_W = $clog2(TOKEN_TRIES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_BYTES - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(TOKEN_TRIES - 1);

  logic rst_ns;
  sdx_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  logic [ADDR_W-1:0] mapped_addr;
  sdx_addr_map #(.ADDR_W(ADDR_W), .BLK_LOG2(IDX_W)) u_map (
    .byte_addr(byte_addr), .high_cap(high_cap), .card_addr(mapped_addr));

  sdx_status_e resp_code;
  sdx_resp_decode u_dec (.tok(spi_rx[4:0]), .code(resp_code));

  sdx_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [TRY_W-1:0]  tries_q, tries_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              multi_q, multi_d;
  sdx_status_e       status_q, status_d;
  logic [7:0]        data_q, data_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    tries_d  = tries_q;
    left_d   = left_q;
    multi_d  = multi_q;
    status_d = status_q;
    data_d   = data_q;
    addr_d   = addr_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        addr_d   = mapped_addr;
        multi_d  = blk_count > CNT_W'(1);
        left_d   = (blk_count == '0) ? CNT_W'(1) : blk_count;
        status_d = XS_OK;
        tries_d  = '0;
        idx_d    = '0;
        state_d  = is_write ? S_WTOK : S_RTOK;
      end
      S_RTOK: if (spi_ack) begin
        if (spi_rx == TK_SINGLE) begin
          idx_d   = '0;
          state_d = S_RDAT;
        end else if (tries_q == TRY_LAST) begin
          status_d = XS_TIMEOUT;
          state_d  = S_DONE;
        end else begin
          tries_d = tries_q + TRY_W'(1);
        end
      end
      S_RDAT: if (spi_ack) begin
        data_d  = spi_rx;
        state_d = S_RPUSH;
      end
      S_RPUSH: if (rd_ready) begin
        if (idx_q == IDX_LAST) begin
          idx_d   = '0;
          state_d = S_RCRC;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = S_RDAT;
        end
      end
      S_RCRC: if (spi_ack) begin
        if (idx_q == IDX_W'(1)) begin
          if (left_q == CNT_W'(1)) state_d = S_DONE;
          else begin
            left_d  = left_q - CNT_W'(1);
            tries_d = '0;
            state_d = S_RTOK;
          end
        end else begin
          idx_d = IDX_W'(1);
        end
      end
      S_WTOK: if (spi_ack) begin
        idx_d   = '0;
        state_d = S_WFETCH;
      end
      S_WFETCH: if (wr_valid) begin
        data_d  = wr_data;
        state_d = S_WDAT;
      end
      S_WDAT: if (spi_ack) begin
        if (idx_q == IDX_LAST) begin
          idx_d   = '0;
          state_d = S_WCRC;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = S_WFETCH;
        end
      end
      S_WCRC: if (spi_ack) begin
        if (idx_q == IDX_W'(1)) state_d = S_WRESP;
        else                    idx_d   = IDX_W'(1);
      end
      S_WRESP: if (spi_ack) begin
        status_d = resp_code;
        state_d  = S_WBUSY;
      end
      S_WBUSY: if (spi_ack && spi_rx == FILL) begin
        if (status_q != XS_OK || left_q == CNT_W'(1)) begin
          state_d = multi_q ? S_WSTOP : S_DONE;
        end else begin
          left_d  = left_q - CNT_W'(1);
          state_d = S_WTOK;
        end
      end
      S_WSTOP: if (spi_ack) begin
        idx_d   = '0;
        state_d = S_SBUSY;
      end
      S_SBUSY: if (spi_ack) begin
        if (idx_q == '0)          idx_d   = IDX_W'(1);
        else if (spi_rx == FILL)  state_d = S_DONE;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      tries_q  <= '0;
      left_q   <= '0;
      multi_q  <= 1'b0;
      status_q <= XS_OK;
      data_q   <= '0;
      addr_q   <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      tries_q  <= tries_d;
      left_q   <= left_d;
      multi_q  <= multi_d;
      status_q <= status_d;
      data_q   <= data_d;
      addr_q   <= addr_d;
    end
  end

  // outputs
  always_comb begin
    unique case (state_q)
      S_WTOK:  spi_tx = multi_q ? TK_MULTI : TK_SINGLE;
      S_WDAT:  spi_tx = data_q;
      S_WSTOP: spi_tx = TK_STOP;
      default: spi_tx = FILL;
    endcase
  end

  assign spi_req   = !(state_q inside {S_IDLE, S_RPUSH, S_WFETCH, S_DONE});
  assign busy      = state_q != S_IDLE;
  assign done      = state_q == S_DONE;
  assign status    = status_q;
  assign rd_valid  = state_q == S_RPUSH;
  assign rd_data   = data_q;
  assign wr_ready  = state_q == S_WFETCH;
  assign card_addr = addr_q;
  assign multi     = multi_q;

  // assertions
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(spi_req && !spi_ack) |-> spi_req && spi_tx == $past(spi_tx));
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(rd_valid && !rd_ready) |-> rd_valid && rd_data == $past(rd_data));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done && !busy);
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_ns)
    start && !busy |=> busy);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(busy) && busy |-> $stable(card_addr) && $stable(multi));
  a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_ns)
    state_q == S_RTOK |-> tries_q <= TRY_LAST);
endmodule

// File: tb/sdx_block_xfer_bench.sv
`timescale 1ns/1ps
module sdx_block_xfer_bench;
  localparam int BLK   = 512;
  localparam int TRIES = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, is_write, high_cap;
  logic [15:0] blk_count;
  logic [31:0] byte_addr;
  logic        busy, multi, done;
  logic [31:0] card_addr;
  logic [2:0]  status;
  logic        spi_req, spi_ack;
  logic [7:0]  spi_tx, spi_rx;
  logic [7:0]  rd_data, wr_data;
  logic        rd_valid, rd_ready, wr_valid, wr_ready;

  sdx_block_xfer #(.TOKEN_TRIES(TRIES)) u_sdx_block_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
    .high_cap(high_cap), .blk_count(blk_count), .byte_addr(byte_addr),
    .busy(busy), .multi(multi), .card_addr(card_addr), .done(done),
    .status(status), .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack),
    .spi_rx(spi_rx), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready));

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] q_rx[$], q_tx[$], q_rd[$], q_wr[$];
  int  lat = 0, lat_cfg = 0;
  bit  rd_stall = 1'b0, prev_hold = 1'b0, wr_fire = 1'b0;
  int  rd_pat = 0, wr_pat = 0;
  logic [7:0] prev_data, e_tx, e_rd;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // card model and tx scoreboard (R11, R6)
  always @(negedge clk) begin
    if (!rst_n) begin
      spi_ack = 1'b0; lat = 0; spi_rx = 8'hFF;
    end else if (spi_ack) begin
      spi_ack = 1'b0; lat = lat_cfg;
    end else if (spi_req) begin
      if (lat != 0) lat--;
      else begin
        if (q_tx.size() == 0) chk(1'b0, "R6 unexpected exchange", 32'(spi_tx), 32'h0);
        else begin
          e_tx = q_tx.pop_front();
          chk(spi_tx == e_tx, "R11 sent byte", 32'(spi_tx), 32'(e_tx));
        end
        if (q_rx.size() > 0) spi_rx = q_rx.pop_front();
        else spi_rx = 8'hFF;
        spi_ack = 1'b1;
      end
    end
  end

  // read monitor (R4, R5)
  always @(negedge clk) begin
    if (!rst_n) rd_ready = 1'b0;
    else begin
      if (prev_hold)
        chk(rd_valid && rd_data == prev_data, "R5 held read byte", 32'({rd_valid, rd_data}), 32'({1'b1, prev_data}));
      rd_pat++;
      rd_ready = rd_stall ? (rd_pat % 3 != 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        if (q_rd.size() == 0) chk(1'b0, "R4 extra read byte", 32'(rd_data), 32'h0);
        else begin
          e_rd = q_rd.pop_front();
          chk(rd_data == e_rd, "R4 read byte", 32'(rd_data), 32'(e_rd));
        end
      end
      prev_hold = rd_valid && !rd_ready;
      prev_data = rd_data;
    end
  end

  // write stream driver
  always @(negedge clk) begin
    if (!rst_n) begin
      wr_valid = 1'b0; wr_data = 8'h00; wr_fire = 1'b0;
    end else begin
      if (wr_fire && q_wr.size() > 0) void'(q_wr.pop_front());
      wr_pat++;
      wr_valid = (q_wr.size() > 0) && (wr_pat % 4 != 1);
      wr_data  = (q_wr.size() > 0) ? q_wr[0] : 8'h00;
      wr_fire  = wr_valid && wr_ready;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 7 + i * 13 + (i >> 3));
  endfunction

  task automatic xchg(input logic [7:0] tx, input logic [7:0] rx);
    q_tx.push_back(tx); q_rx.push_back(rx);
  endtask

  task automatic read_block(input int fills, input int seed);
    for (int i = 0; i < fills; i++) xchg(8'hFF, (i % 2 == 0) ? 8'hFF : 8'(i));
    xchg(8'hFF, 8'hFE);
    for (int i = 0; i < BLK; i++) begin
      xchg(8'hFF, pat(seed, i)); q_rd.push_back(pat(seed, i));
    end
    xchg(8'hFF, 8'hA5); xchg(8'hFF, 8'h5A);
  endtask

  task automatic write_block(input logic [7:0] tok, input int seed, input logic [7:0] resp, input int busyn);
    xchg(tok, 8'hFF);
    for (int i = 0; i < BLK; i++) begin
      xchg(pat(seed, i), 8'hFF); q_wr.push_back(pat(seed, i));
    end
    xchg(8'hFF, 8'hFF); xchg(8'hFF, 8'hFF);
    xchg(8'hFF, resp);
    for (int i = 0; i < busyn; i++) xchg(8'hFF, 8'h00);
    xchg(8'hFF, 8'hFF);
  endtask

  task automatic stop_seq(input int busyn);
    xchg(8'hFD, 8'hFF);
    xchg(8'hFF, 8'hFF);
    for (int i = 0; i < busyn; i++) xchg(8'hFF, 8'h00);
    xchg(8'hFF, 8'hFF);
  endtask

  task automatic run_op(input bit w, input bit hc, input logic [15:0] cnt, input logic [31:0] addr,
                        input logic [2:0] exp_st, input bit poke, input int wr_left, input string tag);
    logic [31:0] exp_addr;
    exp_addr = hc ? (addr >> 9) : addr;
    @(negedge clk);
    start = 1'b1; is_write = w; high_cap = hc; blk_count = cnt; byte_addr = addr;
    @(negedge clk);
    start = 1'b0;
    chk(busy, {tag, " R2 busy after start"}, 32'(busy), 32'h1);
    chk(card_addr == exp_addr, {tag, " R2 card address"}, card_addr, exp_addr);
    chk(multi == (cnt > 1), {tag, " R2 multi flag"}, 32'(multi), 32'(cnt > 1));
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; is_write = ~w; byte_addr = 32'hFFFF_FFF0; blk_count = 16'd7;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(status == exp_st, {tag, " R7/R3 status at done"}, 32'(status), 32'(exp_st));
    chk(card_addr == exp_addr, {tag, " R10 address kept"}, card_addr, exp_addr);
    chk(q_tx.size() == 0, {tag, " R6 all exchanges made"}, 32'(q_tx.size()), 32'h0);
    chk(q_rx.size() == 0, {tag, " R8 all replies used"}, 32'(q_rx.size()), 32'h0);
    chk(q_rd.size() == 0, {tag, " R4 all read bytes out"}, 32'(q_rd.size()), 32'h0);
    chk(q_wr.size() == wr_left, {tag, " R9 write bytes fetched"}, 32'(q_wr.size()), 32'(wr_left));
    @(negedge clk);
    chk(!done && !busy, {tag, " R10 done pulse"}, 32'({done, busy}), 32'h0);
    q_wr.delete();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_write = 1'b0; high_cap = 1'b0;
    blk_count = '0; byte_addr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !spi_req && !rd_valid && !wr_ready, "R1 reset state",
        32'({busy, done, spi_req, rd_valid, wr_ready}), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !spi_req && !wr_ready, "R1 idle after reset", 32'({busy, spi_req, wr_ready}), 32'h0);

    // R3 R4: single read, high capacity, junk before token, stalled consumer
    rd_stall = 1'b1; lat_cfg = 0;
    read_block(3, 1);
    run_op(1'b0, 1'b1, 16'd1, 32'h0004_0200, 3'd0, 1'b0, 0, "rd1");
    // R4: three-block read, byte address, slower card
    lat_cfg = 2;
    read_block(0, 2); read_block(5, 3); read_block(1, 4);
    run_op(1'b0, 1'b0, 16'd3, 32'h0000_1234, 3'd0, 1'b0, 0, "rd3");
    // R3: token never arrives
    lat_cfg = 0; rd_stall = 1'b0;
    for (int i = 0; i < TRIES; i++) xchg(8'hFF, 8'hFF);
    run_op(1'b0, 1'b0, 16'd1, 32'h0000_0400, 3'd1, 1'b0, 0, "rdto");
    // R3: token on the last allowed poll
    read_block(TRIES - 1, 5);
    run_op(1'b0, 1'b1, 16'd0, 32'h0000_0000, 3'd0, 1'b0, 0, "rdlast");
    // R6 R7 R8: single writes with every response class; R10 start ignored
    lat_cfg = 1;
    write_block(8'hFE, 6, 8'hE5, 4);
    run_op(1'b1, 1'b1, 16'd1, 32'h0010_0000, 3'd0, 1'b1, 0, "wr_ok");
    write_block(8'hFE, 7, 8'h0B, 2);
    run_op(1'b1, 1'b0, 16'd1, 32'h0000_0200, 3'd2, 1'b0, 0, "wr_crc");
    write_block(8'hFE, 8, 8'hED, 3);
    run_op(1'b1, 1'b0, 16'd0, 32'h0000_0600, 3'd3, 1'b1, 0, "wr_err");
    write_block(8'hFE, 9, 8'h1F, 0);
    run_op(1'b1, 1'b1, 16'd1, 32'h0000_0800, 3'd4, 1'b0, 0, "wr_rej");
    // R9: multi-block write, all accepted
    lat_cfg = 0;
    write_block(8'hFC, 10, 8'h05, 1); write_block(8'hFC, 11, 8'h05, 0);
    write_block(8'hFC, 12, 8'h05, 3); stop_seq(5);
    run_op(1'b1, 1'b0, 16'd3, 32'h0000_A000, 3'd0, 1'b0, 0, "wrm_ok");
    // R9: multi-block write stopped by a CRC error on block 2 of 4
    write_block(8'hFC, 13, 8'h05, 0); write_block(8'hFC, 14, 8'h0B, 2); stop_seq(2);
    for (int i = 0; i < BLK; i++) q_wr.push_back(pat(15, i));
    run_op(1'b1, 1'b1, 16'd4, 32'h0002_0000, 3'd2, 1'b0, BLK, "wrm_err");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule